// File: doc/BRIEF.md
# Reset Cause Status Register

This block records which event brought the system out of its most recent reset or stop-mode recovery. The capture logic takes single-cycle event pulses from the power-on circuit, the stop-mode wake-up logic, the watchdog and the debug logic. It also takes the raw, active-low external reset pin and filters it against glitches itself. A stop-mode flag tells it whether an event arrived while the device was stopped. Software reads the result as one byte at a configurable bus address, and that read clears the cause bits. The same address also accepts writes, which land in a separate watchdog control register. That register drives the watchdog and cannot be read back.

The external pin passes through a synchronizer and a counter. A low level must persist for `FILT_LEN` consecutive clock samples before the filter raises a one-cycle `ext_rst_req` toward the system reset logic. The same qualified pulse records an external cause in the status byte. A debug-initiated reset is reported the same way as a power-on reset.

The bus port is a plain register port, not a stream. It has no ready signal and never applies back-pressure. Every read that hits the address returns data on the following cycle, flagged by `bus_rvalid`.

Top module: `rst_cause_reg`

## Requirements
- R1: After `arst_n` is released, a read of the register returns 0x80 and `wdt_ctl` equals 0x00.
- R2: The read byte carries the power-on cause at bit 7, the stop-mode cause at bit 6, the watchdog cause at bit 5 and the external-pin cause at bit 4. Bits 3 to 0 always read as 0.
- R3: A read at `BASE_ADDR` (default 0xFF0) raises `bus_rvalid` with the data exactly one cycle later. A read at any other address leaves `bus_rvalid` low.
- R4: A read that hits the register clears bits 7 to 4, so the next read returns 0x00.
- R5: A write at `BASE_ADDR` loads `bus_wdata` into `wdt_ctl` and leaves the status byte unchanged. Reads never return the `wdt_ctl` value.
- R6: The register ignores a low pulse on `ext_rst_n` shorter than `FILT_LEN` (default 3) clock samples. A low pulse of `FILT_LEN` samples or longer sets bit 4 and produces exactly one single-cycle `ext_rst_req` per low period.
- R7: A new event replaces all previously recorded cause bits with the new cause.
- R8: An event that arrives while `in_stop` is high also sets bit 6. A stop-mode recovery pulse alone sets only bit 6.
- R9: A debug-initiated reset sets bit 7, the power-on cause.
- R10: When an event and a hitting read occur in the same cycle, the read returns the old byte and the new cause stays recorded.
- R11: Events that arrive in the same cycle all set their bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset of this block (power domain reset) |
| por_evt | input | 1 | Power-on reset event pulse |
| smr_evt | input | 1 | Stop-mode recovery event pulse |
| wdt_evt | input | 1 | Watchdog time-out event pulse |
| dbg_evt | input | 1 | Debug-initiated reset event pulse |
| in_stop | input | 1 | High while the device is in stop mode |
| ext_rst_n | input | 1 | Raw external reset pin, active low, asynchronous |
| ext_rst_req | output | 1 | One-cycle pulse for a qualified external reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a hitting read |
| wdt_ctl | output | 8 | Watchdog control register contents |

## Verification
The bench aims at the boundary of the glitch filter. A pulse one sample too short must leave the byte at zero, and a pulse exactly `FILT_LEN` samples long must set the external cause. An off-by-one counter would do one or the other wrongly, and a filter that fails to hold after firing would emit repeated requests on a long low. The bench also collides a read with a new event in the same cycle. A design that gives clear-on-read priority would lose the new cause. It further checks that a debug reset appears as a power-on cause and that stop mode adds bit 6. Finally, it writes the shared address and then reads it, which would expose any leak of the watchdog control value into the read path or any write that disturbs the status byte.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  // Cause bits, packed so that {stat, 4'b0} forms the read byte (por at bit 7)
  typedef struct packed {
    logic por;
    logic stp;
    logic wdt;
    logic ext;
  } rsf_stat_t;

  localparam rsf_stat_t STAT_AFTER_RESET = '{por: 1'b1, stp: 1'b0, wdt: 1'b0, ext: 1'b0};
  localparam int RSVD_W = 4;
endpackage

// File: rtl/rsf_pin_filter.sv
module rsf_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_n,
  output logic evt
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   pin_low;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
  end

  assign pin_low = ~sync_q[SYNC_STAGES-1];

  // Count consecutive low samples, saturating at FILT_LEN so one low period fires once
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      evt   <= 1'b0;
    end else begin
      evt <= pin_low && (cnt_q == CW'(FILT_LEN - 1));
      if (!pin_low)                    cnt_q <= '0;
      else if (cnt_q != CW'(FILT_LEN)) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_FILT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
    evt |=> !evt); // R6
  AST_FILT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(evt) |-> $past(pin_low)); // R6
endmodule

// File: rtl/rsf_status.sv
module rsf_status
  import rsf_pkg::*;
(
  input  logic      clk,
  input  logic      arst_n,
  input  logic      por_evt,
  input  logic      smr_evt,
  input  logic      wdt_evt,
  input  logic      dbg_evt,
  input  logic      ext_evt,
  input  logic      in_stop,
  input  logic      clr,
  output rsf_stat_t stat
);
  logic      any_evt;
  rsf_stat_t next_cause;

  assign any_evt = por_evt | smr_evt | wdt_evt | dbg_evt | ext_evt;

  always_comb begin
    next_cause.por = por_evt | dbg_evt;
    next_cause.stp = smr_evt | (in_stop & any_evt);
    next_cause.wdt = wdt_evt;
    next_cause.ext = ext_evt;
  end

  // A new event outranks clear-on-read
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      stat <= STAT_AFTER_RESET;
    else if (any_evt) stat <= next_cause;
    else if (clr)     stat <= '0;
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!arst_n)
    (clr && !any_evt) |=> (stat == '0)); // R4
  AST_EVT_RECORDED: assert property (@(posedge clk) disable iff (!arst_n)
    any_evt |=> (stat != '0)); // R10
  AST_DBG_AS_POR: assert property (@(posedge clk) disable iff (!arst_n)
    dbg_evt |=> stat.por); // R9
  AST_STOP_FLAG: assert property (@(posedge clk) disable iff (!arst_n)
    (any_evt && in_stop) |=> stat.stp); // R8
endmodule

// File: rtl/rsf_bus.sv
module rsf_bus
  import rsf_pkg::*;
#(
  parameter int              ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 12'hFF0,
  parameter logic [7:0]      WDT_CTL_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  rsf_stat_t         stat,
  output logic              rd_hit,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  output logic [7:0]        wdt_ctl
);
  logic hit, wr_hit;

  assign hit    = (bus_addr == BASE_ADDR);
  assign rd_hit = bus_rd & hit;
  assign wr_hit = bus_wr & hit;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      bus_rdata  <= 8'h00;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_hit;
      bus_rdata  <= rd_hit ? {stat, {RSVD_W{1'b0}}} : 8'h00;
    end
  end

  // Write-only watchdog control sharing the address
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     wdt_ctl <= WDT_CTL_INIT;
    else if (wr_hit) wdt_ctl <= bus_wdata;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    bus_rvalid |-> (bus_rdata[3:0] == 4'h0)); // R2
  AST_MISS_NO_VALID: assert property (@(posedge clk) disable iff (!arst_n)
    (bus_rd && !hit) |=> !bus_rvalid); // R3
  AST_WDT_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    !wr_hit |=> $stable(wdt_ctl)); // R5
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rsf_pkg::*;
#(
  parameter int                ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = 12'hFF0,
  parameter int                SYNC_STAGES  = 2,
  parameter int                FILT_LEN     = 3,
  parameter logic [7:0]        WDT_CTL_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              por_evt,
  input  logic              smr_evt,
  input  logic              wdt_evt,
  input  logic              dbg_evt,
  input  logic              in_stop,
  input  logic              ext_rst_n,
  output logic              ext_rst_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  output logic [7:0]        wdt_ctl
);
  rsf_stat_t stat;
  logic      rd_hit;

  rsf_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .arst_n(arst_n), .pin_n(ext_rst_n), .evt(ext_rst_req)
  );

  rsf_status u_stat (
    .clk(clk), .arst_n(arst_n),
    .por_evt(por_evt), .smr_evt(smr_evt), .wdt_evt(wdt_evt), .dbg_evt(dbg_evt),
    .ext_evt(ext_rst_req), .in_stop(in_stop), .clr(rd_hit), .stat(stat)
  );

  rsf_bus #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WDT_CTL_INIT(WDT_CTL_INIT)) u_bus (
    .clk(clk), .arst_n(arst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .stat(stat), .rd_hit(rd_hit), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .wdt_ctl(wdt_ctl)
  );
endmodule

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;
  localparam logic [11:0] ADDR = 12'hFF0;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic por_evt = 0, smr_evt = 0, wdt_evt = 0, dbg_evt = 0, in_stop = 0;
  logic ext_rst_n = 1'b1;
  logic ext_rst_req;
  logic [11:0] bus_addr = ADDR;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, wdt_ctl;
  logic bus_rvalid;

  int checks = 0, errors = 0, req_pulses = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  rst_cause_reg u_dut (
    .clk(clk), .arst_n(arst_n), .por_evt(por_evt), .smr_evt(smr_evt), .wdt_evt(wdt_evt),
    .dbg_evt(dbg_evt), .in_stop(in_stop), .ext_rst_n(ext_rst_n), .ext_rst_req(ext_rst_req),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .wdt_ctl(wdt_ctl)
  );

  always @(negedge clk) if (arst_n && ext_rst_req) req_pulses++;

  // Vector: [12:8] {por, smr, wdt, dbg, stop}, [7:0] expected byte
  localparam int NV = 7;
  localparam logic [12:0] VEC [NV] = '{
    {5'b10000, 8'h80},   // R9 family: power-on
    {5'b00100, 8'h20},   // watchdog
    {5'b00101, 8'h60},   // R8 watchdog in stop
    {5'b01000, 8'h40},   // R8 stop recovery alone
    {5'b00010, 8'h80},   // R9 debug as power-on
    {5'b00011, 8'hC0},   // R9 R8 debug in stop
    {5'b10100, 8'hA0}    // R11 simultaneous
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic do_read(input logic [11:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = ADDR;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic fire(input logic [4:0] e);
    @(negedge clk);
    {por_evt, smr_evt, wdt_evt, dbg_evt, in_stop} = e;
    @(negedge clk);
    {por_evt, smr_evt, wdt_evt, dbg_evt, in_stop} = 5'b0;
  endtask

  task automatic pin_low(input int n);
    @(negedge clk);
    ext_rst_n = 1'b0;
    repeat (n) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    logic v;
    int p0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 wdt_ctl", wdt_ctl, 8'h00);
    do_read(ADDR, d, v);
    check("R1 read", d, 8'h80);
    check("R3 rvalid", {7'b0, v}, 8'h01);
    do_read(ADDR, d, v);
    check("R4 cleared", d, 8'h00);

    // Vector table walk: R2 bit layout
    for (int i = 0; i < NV; i++) begin
      fire(VEC[i][12:8]);
      do_read(ADDR, d, v);
      check("R2 vector", d, VEC[i][7:0]);
    end

    // R3 miss address
    fire(5'b00100);
    do_read(12'h123, d, v);
    check("R3 miss rvalid", {7'b0, v}, 8'h00);
    // R7 replacement
    fire(5'b10000);
    do_read(ADDR, d, v);
    check("R7 replaced", d, 8'h80);

    // R5 write to shared address
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 8'h5A;
    fire(5'b00100);
    bus_wr = 1'b0;
    check("R5 wdt_ctl", wdt_ctl, 8'h5A);
    do_read(ADDR, d, v);
    check("R5 read not wdt", d, 8'h20);

    // R10 collision of read and event
    fire(5'b01000);
    @(negedge clk);
    bus_rd = 1'b1; wdt_evt = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; wdt_evt = 1'b0;
    check("R10 old data", bus_rdata, 8'h40);
    do_read(ADDR, d, v);
    check("R10 kept", d, 8'h20);

    // R6 glitch filter
    p0 = req_pulses;
    pin_low(2);
    do_read(ADDR, d, v);
    check("R6 short ignored", d, 8'h00);
    check("R6 no req", 8'(req_pulses - p0), 8'h00);
    pin_low(3);
    do_read(ADDR, d, v);
    check("R6 min width", d, 8'h10);
    check("R6 one req", 8'(req_pulses - p0), 8'h01);
    pin_low(10);
    do_read(ADDR, d, v);
    check("R6 long low", d, 8'h10);
    check("R6 single per low", 8'(req_pulses - p0), 8'h02);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule